// File: doc/BRIEF.md
# Pipelined Blake2b Mixing Round

This block computes one round of the Blake2b compression mixing as a fixed-latency pipeline. Every clock it can take a new 16-word state vector of 64-bit words, plus the 16 message words of the same candidate. The mixed state comes out eight cycles later. Because a new candidate can enter on every clock, a chain of these rounds sustains one hash per cycle once it is full.

Inside the round there are two groups of four mixing units in series. The first group works on the columns of the 4x4 state matrix and the second on its diagonals. Each mixing unit takes four clock cycles and holds one register stage after each of its add/xor/rotate steps. A parameter sets the round's index. The index picks the row of the message schedule that decides which message words feed each unit. A valid flag travels with the data.

Chaining rounds, the final feed-forward XOR and nonce generation are done by the logic around this block.

Top module: `blk2_round_pipe`

## Requirements
- R1: While reset is held, and until the first sampled valid input has crossed the pipeline, `out_valid` is low.
- R2: A sample taken at rising edge k leaves through exactly 8 register stages. `out_valid` and `out_state` show its result just after edge k+7.
- R3: The pipeline accepts one input on every clock with no stall. Each valid input gives exactly one valid output, and each slot with `in_valid` low gives a slot with `out_valid` low. All mixing units of a group hold the same valid state.
- R4: Each mixing unit runs four register-separated steps on words (a,b,c,d) with message words x,y. Step 1: a=a+b+x, then d=(d^a) rotated right by 32. Step 2: c=c+d, then b=(b^c) rotated right by 24. Step 3: a=a+b+y, then d=(d^a) rotated right by 16. Step 4: c=c+d, then b=(b^c) rotated right by 63. Words that a step does not write pass through that step unchanged.
- R5: All additions wrap modulo 2^64.
- R6: Word j of the state sits at bits [64j+63:64j]. The column units mix words (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15) in the first four cycles.
- R7: The diagonal units then mix words (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14) of the column result. Each result is written back to the same word position.
- R8: With schedule row s = ROUND_IDX mod 10, column unit i takes x = msg[s[2i]] and y = msg[s[2i+1]]. Diagonal unit i takes x = msg[s[8+2i]] and y = msg[s[9+2i]]. The message words come from the same edge as the state. The standard Blake2b schedule is used, so round indices 10 and 11 reuse rows 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid pipeline |
| in_valid | input | 1 | Marks the current state and message as a candidate |
| in_state | input | 16*WORD_W | Input state vector, word j at bits [WORD_W*j +: WORD_W] |
| in_msg | input | 16*WORD_W | Message words for this candidate, same packing |
| out_valid | output | 1 | Marks `out_state` as a mixed result |
| out_state | output | 16*WORD_W | Mixed state vector, same packing |

## Verification
Single-bit state vectors, one per word position, show whether each word is routed into the correct column and diagonal unit. The all-ones vector, with all-ones message words, drives carries through every adder, which separates wrapping arithmetic from truncation errors. A long stream of random vectors on every clock checks throughput and the full arithmetic. A random valid pattern with gaps shows whether bubbles and results stay aligned. A second instance with round index 11 uses the same stimulus to check that the message schedule row is selected from the index.

// File: rtl/blk2_mix_pkg.sv
package blk2_mix_pkg;

   localparam int SCHED_ROWS = 10;

   // Message schedule, one row per entry, position p in nibble p (p = 0 at LSB).
   localparam logic [63:0] SCHED_TAB [SCHED_ROWS] = '{
      64'hFEDCBA9876543210,
      64'h357B20C16DF984AE,
      64'h491763EADF250C8B,
      64'h8F04A562EBCD1397,
      64'hD386CB1EFA427509,
      64'h91EF57D438B0A6C2,
      64'hB8293670A4DEF15C,
      64'hA2684F05931CE7BD,
      64'h5A417D2C803B9EF6,
      64'h0DC3E9BF5167482A
   };

   // Message word index for schedule position pos in a given round.
   function automatic int sched_pick(input int round_idx, input int pos);
      logic [63:0] row;
      row = SCHED_TAB[round_idx % SCHED_ROWS];
      return int'(row[pos*4 +: 4]);
   endfunction

   // State word index for unit u, role r (0=a,1=b,2=c,3=d), column or diagonal.
   function automatic int lane_of(input bit diag, input int u, input int r);
      return r*4 + (diag ? (u + r) % 4 : u);
   endfunction

endpackage

// File: rtl/blk2_g_pipe.sv
module blk2_g_pipe #(
   parameter int W  = 64,
   parameter int R0 = 32,
   parameter int R1 = 24,
   parameter int R2 = 16,
   parameter int R3 = 63
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   input  logic [W-1:0] d_i,
   input  logic [W-1:0] m0_i,
   input  logic [W-1:0] m1_i,
   output logic         vld_o,
   output logic [W-1:0] a_o,
   output logic [W-1:0] b_o,
   output logic [W-1:0] c_o,
   output logic [W-1:0] d_o
);
   localparam int NSTEP = 4;
   localparam int MHOLD = 2;

   if (R0 < 1 || R0 >= W || R1 < 1 || R1 >= W ||
       R2 < 1 || R2 >= W || R3 < 1 || R3 >= W) begin : g_bad_rot
      $error("blk2_g_pipe: rotation amounts must lie in 1..W-1");
   end

   function automatic logic [W-1:0] rotr(input logic [W-1:0] x, input int n);
      return (x >> n) | (x << (W - n));
   endfunction

   logic [W-1:0] a_x [NSTEP];
   logic [W-1:0] b_x [NSTEP];
   logic [W-1:0] c_x [NSTEP];
   logic [W-1:0] d_x [NSTEP];
   logic [W-1:0] a_q [NSTEP];
   logic [W-1:0] b_q [NSTEP];
   logic [W-1:0] c_q [NSTEP];
   logic [W-1:0] d_q [NSTEP];
   logic [W-1:0] m1_q [MHOLD];
   logic [NSTEP-1:0] v_q;

   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      localparam int ROT = (k == 0) ? R0 : (k == 1) ? R1 : (k == 2) ? R2 : R3;
      logic [W-1:0] ai, bi, ci, di;
      if (k == 0) begin : g_src_port
         assign ai = a_i;
         assign bi = b_i;
         assign ci = c_i;
         assign di = d_i;
      end else begin : g_src_reg
         assign ai = a_q[k-1];
         assign bi = b_q[k-1];
         assign ci = c_q[k-1];
         assign di = d_q[k-1];
      end
      if (k % 2 == 0) begin : g_add_step
         logic [W-1:0] mw, sum;
         assign mw     = (k == 0) ? m0_i : m1_q[MHOLD-1];
         assign sum    = ai + bi + mw;
         assign a_x[k] = sum;
         assign d_x[k] = rotr(di ^ sum, ROT);
         assign b_x[k] = bi;
         assign c_x[k] = ci;
      end else begin : g_mix_step
         logic [W-1:0] sum;
         assign sum    = ci + di;
         assign c_x[k] = sum;
         assign b_x[k] = rotr(bi ^ sum, ROT);
         assign a_x[k] = ai;
         assign d_x[k] = di;
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < NSTEP; k++) begin
         a_q[k] <= a_x[k];
         b_q[k] <= b_x[k];
         c_q[k] <= c_x[k];
         d_q[k] <= d_x[k];
      end
      m1_q[0] <= m1_i;
      for (int s = 1; s < MHOLD; s++) m1_q[s] <= m1_q[s-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= {v_q[NSTEP-2:0], vld_i};
   end

   assign vld_o = v_q[NSTEP-1];
   assign a_o   = a_q[NSTEP-1];
   assign b_o   = b_q[NSTEP-1];
   assign c_o   = c_q[NSTEP-1];
   assign d_o   = d_q[NSTEP-1];

   // R4: undoing the first rotation recovers the xor with the old d word
   p_step1_rot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[0] |-> ((rotr(d_q[0], W - R0) ^ $past(d_i)) == a_q[0]));

   // R4: undoing the second rotation recovers the xor with the old b word
   p_step2_rot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[1] |-> ((rotr(b_q[1], W - R1) ^ $past(b_q[0])) == c_q[1]));

   // R4: words not written by the first step pass through unchanged
   p_step1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[0] |-> (b_q[0] == $past(b_i) && c_q[0] == $past(c_i)));

endmodule

// File: rtl/blk2_round_pipe.sv
module blk2_round_pipe
   import blk2_mix_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int ROUND_IDX = 0,
   parameter int ROT_A     = 32,
   parameter int ROT_B     = 24,
   parameter int ROT_C     = 16,
   parameter int ROT_D     = 63
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [16*WORD_W-1:0]   in_state,
   input  logic [16*WORD_W-1:0]   in_msg,
   output logic                   out_valid,
   output logic [16*WORD_W-1:0]   out_state
);
   localparam int NLANE    = 16;
   localparam int NUNIT    = 4;
   localparam int HALF_LAT = 4;
   localparam int LAT      = 2 * HALF_LAT;
   localparam int NDMSG    = 2 * NUNIT;
   localparam int CNT_W    = $clog2(LAT + 1);

   if (ROUND_IDX < 0 || ROUND_IDX > 11) begin : g_bad_round
      $error("blk2_round_pipe: ROUND_IDX must lie in 0..11");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("blk2_round_pipe: WORD_W too small");
   end

   logic [WORD_W-1:0] st_w  [NLANE];
   logic [WORD_W-1:0] msg_w [NLANE];
   logic [WORD_W-1:0] mid_w [NLANE];
   logic [WORD_W-1:0] fin_w [NLANE];
   logic [WORD_W-1:0] dsel  [NDMSG];
   logic [WORD_W-1:0] dm_q  [HALF_LAT][NDMSG];
   logic [NUNIT-1:0]  col_vld;
   logic [NUNIT-1:0]  dia_vld;

   for (genvar j = 0; j < NLANE; j++) begin : g_lane
      assign st_w[j]  = in_state[j*WORD_W +: WORD_W];
      assign msg_w[j] = in_msg[j*WORD_W +: WORD_W];
      assign out_state[j*WORD_W +: WORD_W] = fin_w[j];
   end

   // Diagonal message words wait out the column half of the round.
   for (genvar j = 0; j < NDMSG; j++) begin : g_dsel
      localparam int SEL = sched_pick(ROUND_IDX, NDMSG + j);
      assign dsel[j] = msg_w[SEL];
   end

   always_ff @(posedge clk) begin
      for (int j = 0; j < NDMSG; j++) begin
         dm_q[0][j] <= dsel[j];
         for (int s = 1; s < HALF_LAT; s++) dm_q[s][j] <= dm_q[s-1][j];
      end
   end

   for (genvar u = 0; u < NUNIT; u++) begin : g_col
      localparam int LA = lane_of(1'b0, u, 0);
      localparam int LB = lane_of(1'b0, u, 1);
      localparam int LC = lane_of(1'b0, u, 2);
      localparam int LD = lane_of(1'b0, u, 3);
      localparam int MX = sched_pick(ROUND_IDX, 2*u);
      localparam int MY = sched_pick(ROUND_IDX, 2*u + 1);
      blk2_g_pipe #(.W(WORD_W), .R0(ROT_A), .R1(ROT_B), .R2(ROT_C), .R3(ROT_D)) i_g (
         .clk(clk), .rst_n(rst_n), .vld_i(in_valid),
         .a_i(st_w[LA]), .b_i(st_w[LB]), .c_i(st_w[LC]), .d_i(st_w[LD]),
         .m0_i(msg_w[MX]), .m1_i(msg_w[MY]),
         .vld_o(col_vld[u]),
         .a_o(mid_w[LA]), .b_o(mid_w[LB]), .c_o(mid_w[LC]), .d_o(mid_w[LD]));
   end

   for (genvar u = 0; u < NUNIT; u++) begin : g_dia
      localparam int LA = lane_of(1'b1, u, 0);
      localparam int LB = lane_of(1'b1, u, 1);
      localparam int LC = lane_of(1'b1, u, 2);
      localparam int LD = lane_of(1'b1, u, 3);
      blk2_g_pipe #(.W(WORD_W), .R0(ROT_A), .R1(ROT_B), .R2(ROT_C), .R3(ROT_D)) i_g (
         .clk(clk), .rst_n(rst_n), .vld_i(col_vld[0]),
         .a_i(mid_w[LA]), .b_i(mid_w[LB]), .c_i(mid_w[LC]), .d_i(mid_w[LD]),
         .m0_i(dm_q[HALF_LAT-1][2*u]), .m1_i(dm_q[HALF_LAT-1][2*u + 1]),
         .vld_o(dia_vld[u]),
         .a_o(fin_w[LA]), .b_o(fin_w[LB]), .c_o(fin_w[LC]), .d_o(fin_w[LD]));
   end

   assign out_valid = dia_vld[0];

   // Cycles since reset release, saturating, for the latency check.
   logic [CNT_W-1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                       since_rst <= '0;
      else if (since_rst != CNT_W'(LAT)) since_rst <= since_rst + 1'b1;
   end

   // R1: reset empties the valid pipeline
   p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R2: valid emerges after exactly eight register stages
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == CNT_W'(LAT)) |-> (out_valid == $past(in_valid, 8)));

   // R3: the units of each group advance in lockstep
   p_lockstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((col_vld == '0 || col_vld == '1) && (dia_vld == '0 || dia_vld == '1)));

endmodule

// File: tb/test_blk2_round_pipe.sv
module test_blk2_round_pipe;
   timeunit 1ns;
   timeprecision 1ps;

   typedef logic [63:0]   w64;
   typedef logic [1023:0] vec_t;

   localparam logic [63:0] SCH [10] = '{
      64'hFEDCBA9876543210, 64'h357B20C16DF984AE, 64'h491763EADF250C8B,
      64'h8F04A562EBCD1397, 64'hD386CB1EFA427509, 64'h91EF57D438B0A6C2,
      64'hB8293670A4DEF15C, 64'hA2684F05931CE7BD, 64'h5A417D2C803B9EF6,
      64'h0DC3E9BF5167482A
   };
   localparam int GRP [8][4] = '{
      '{0, 4, 8, 12}, '{1, 5, 9, 13}, '{2, 6, 10, 14}, '{3, 7, 11, 15},
      '{0, 5, 10, 15}, '{1, 6, 11, 12}, '{2, 7, 8, 13}, '{3, 4, 9, 14}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   vec_t in_state = '0;
   vec_t in_msg = '0;
   logic out_valid, out_valid_l;
   vec_t out_state, out_state_l;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit   qv [$];
   vec_t q0 [$];
   vec_t q11 [$];
   int   qph [$];

   always #10 clk = ~clk;

   blk2_round_pipe #(.ROUND_IDX(0)) i_blk2_round_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
      .in_msg(in_msg), .out_valid(out_valid), .out_state(out_state));

   blk2_round_pipe #(.ROUND_IDX(11)) i_blk2_round_pipe_r11 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
      .in_msg(in_msg), .out_valid(out_valid_l), .out_state(out_state_l));

   function automatic w64 ror(input w64 x, input int n);
      return (x >> n) | (x << (64 - n));
   endfunction

   function automatic int sg(input int r, input int p);
      logic [63:0] row;
      row = SCH[r % 10];
      return int'(row[p*4 +: 4]);
   endfunction

   function automatic vec_t ref_round(input vec_t st, input vec_t ms, input int r);
      w64 v [16];
      w64 m [16];
      vec_t res;
      for (int i = 0; i < 16; i++) begin
         v[i] = st[i*64 +: 64];
         m[i] = ms[i*64 +: 64];
      end
      for (int g = 0; g < 8; g++) begin
         int ia, ib, ic, id;
         w64 x, y;
         ia = GRP[g][0]; ib = GRP[g][1]; ic = GRP[g][2]; id = GRP[g][3];
         x = m[sg(r, 2*g)];
         y = m[sg(r, 2*g + 1)];
         v[ia] = v[ia] + v[ib] + x; v[id] = ror(v[id] ^ v[ia], 32);
         v[ic] = v[ic] + v[id];     v[ib] = ror(v[ib] ^ v[ic], 24);
         v[ia] = v[ia] + v[ib] + y; v[id] = ror(v[id] ^ v[ia], 16);
         v[ic] = v[ic] + v[id];     v[ib] = ror(v[ib] ^ v[ic], 63);
      end
      for (int i = 0; i < 16; i++) res[i*64 +: 64] = v[i];
      return res;
   endfunction

   function automatic vec_t rnd_vec();
      vec_t r;
      for (int i = 0; i < 32; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   function automatic string ph_tag(input int ph);
      case (ph)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input vec_t act, input vec_t exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare();
      if (qv.size() >= 8) begin
         bit   v;
         vec_t e0, e11;
         int   ph;
         v = qv.pop_front(); e0 = q0.pop_front(); e11 = q11.pop_front(); ph = qph.pop_front();
         chk(out_valid == v, "R2 valid timing", vec_t'(out_valid), vec_t'(v));
         chk(out_valid_l == v, "R2 valid timing round 11", vec_t'(out_valid_l), vec_t'(v));
         if (v) begin
            chk(out_state == e0, ph_tag(ph), out_state, e0);
            chk(out_state_l == e11, "R8 schedule row for round 11", out_state_l, e11);
         end
      end else begin
         chk(out_valid == 1'b0, "R1 empty after reset", vec_t'(out_valid), '0);
      end
   endtask

   task automatic cycle(input bit v, input vec_t s, input vec_t m, input int ph);
      @(negedge clk);
      compare();
      in_valid = v;
      in_state = s;
      in_msg = m;
      qv.push_back(v);
      q0.push_back(ref_round(s, m, 0));
      q11.push_back(ref_round(s, m, 11));
      qph.push_back(ph);
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk(out_valid == 1'b0 && out_valid_l == 1'b0, "R1 during reset",
             vec_t'(out_valid), '0);
      end
      rst_n = 1'b1;

      // R4: single-bit words, one position at a time, state then message
      for (int j = 0; j < 16; j++) begin
         vec_t s;
         s = '0;
         s[j*64 +: 64] = 64'h1 << j;
         cycle(1'b1, s, '0, 0);
      end
      for (int j = 0; j < 16; j++) begin
         vec_t m;
         m = '0;
         m[j*64 +: 64] = 64'h8000_0000_0000_0001;
         cycle(1'b1, '0, m, 0);
      end
      cycle(1'b1, '0, '0, 0);

      // R5: carries through every adder
      cycle(1'b1, '1, '1, 1);
      cycle(1'b1, '1, '0, 1);
      cycle(1'b1, '0, '1, 1);

      // R6: dense random stream
      for (int n = 0; n < 200; n++) cycle(1'b1, rnd_vec(), rnd_vec(), 2);

      // R7: random stream with bubbles
      for (int n = 0; n < 200; n++) cycle(1'(($urandom % 3) != 0), rnd_vec(), rnd_vec(), 3);

      // R3: alternating valid slots
      for (int n = 0; n < 40; n++) cycle(1'(n % 2), rnd_vec(), rnd_vec(), 4);

      // drain
      for (int n = 0; n < 9; n++) cycle(1'b0, '0, '0, 4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule